// File: doc/BRIEF.md
# Watchdog and Reset Generator

This block drives one system reset output from three causes: power-up, a low supply, and a watchdog timeout. It runs from a free-running timebase clock. It sees a power-good level from an external comparator, a chip-select line that also acts as the watchdog restart, and a two-bit interval select taken from a register. On power-up, and again after the supply recovers, the reset stays asserted for a fixed hold period so that the supply and the oscillator can settle. While reset is asserted, a busy output tells the serial command logic to ignore all reads and writes.

The watchdog counts timebase ticks. Each falling edge of chip-select clears the count. If the count reaches the selected interval before a falling edge arrives, the block asserts reset for one hold period and then starts counting again from zero. A parameter sets the polarity of the reset pin. Inside the block, reset is always active-high. Power-good and chip-select pass through synchronizers of `SYNC_STAGES` flops before any logic uses them.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_ni` is released with `pwr_good_i` high, reset stays asserted for exactly SYNC_STAGES+POR_TICKS clock edges and is then released.
- R2: `cmd_block_o` is high in every cycle in which reset is asserted, and low in every cycle in which it is not.
- R3: When `pwr_good_i` goes low, reset is asserted SYNC_STAGES+1 edges later and stays asserted while the supply is low. After `pwr_good_i` returns high, reset stays asserted for SYNC_STAGES+POR_TICKS more edges.
- R4: With no chip-select activity, reset is asserted L edges after it was last released. L is selected by `wd_sel_i` as follows: 2'b00 gives WD_LONG_TICKS, 2'b01 gives WD_MID_TICKS, and 2'b10 gives WD_SHORT_TICKS.
- R5: When `wd_sel_i` = 2'b11, the watchdog never asserts reset.
- R6: A high-to-low transition of `cs_ni` restarts the watchdog. In that case reset is asserted SYNC_STAGES+1+L edges after the low level is applied. Holding `cs_ni` low gives no further restarts, and a rising edge gives none either.
- R7: A watchdog timeout asserts reset for exactly POR_TICKS edges. The watchdog then counts again from zero, so the next timeout comes L edges after the release.
- R8: With ACTIVE_LOW=1, `sys_rst_o` is low while reset is asserted. With ACTIVE_LOW=0, it is high while reset is asserted.
- R9: The watchdog count is held at zero while reset is asserted, so chip-select edges during reset do not change when the next timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timebase clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pwr_good_i | input | 1 | Supply above trip point (asynchronous) |
| cs_ni | input | 1 | Active-low chip select, also the watchdog restart input |
| wd_sel_i | input | 2 | Watchdog interval select |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_LOW |
| cmd_block_o | output | 1 | Serial command logic must ignore commands while this is high |

## Verification
The bench builds two copies of the block that share all inputs. Both use a hold of 8 ticks, intervals of 60, 40 and 24 ticks, and two synchronizer stages; one copy has an active-low output and the other an active-high output. These short windows let the bench measure every timeout exactly, edge by edge, for all three intervals and for repeated timeouts within a few thousand cycles. Comparing the two copies checks the polarity option on every sample.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= RST_VAL;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[i] <= RST_VAL;
        else         st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rst_sup_hold.sv
module rst_sup_hold #(
  parameter int unsigned POR_TICKS = 16,
  localparam int unsigned HW = $clog2(POR_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic wd_expire_i,
  output logic active_o
);
  logic [HW-1:0] cnt_q;

  // Low supply or timeout reloads the full hold; otherwise count down to zero.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= HW'(POR_TICKS);
    else if (!pwr_ok_i || wd_expire_i) cnt_q <= HW'(POR_TICKS);
    else if (cnt_q != '0)              cnt_q <= cnt_q - HW'(1);
  end

  assign active_o = (cnt_q != '0);

  p_hold_counts_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && !wd_expire_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HW'(1)));
  p_low_supply_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> active_o);
endmodule

// File: rtl/rst_sup_wdog.sv
module rst_sup_wdog
  import rst_sup_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1000,
  parameter int unsigned MID_TICKS   = 400,
  parameter int unsigned SHORT_TICKS = 100,
  localparam int unsigned MAXL = (LONG_TICKS > MID_TICKS)
                                 ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                                 : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS),
  localparam int unsigned W = $clog2(MAXL + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  input  logic       hold_i,
  output logic       expire_o
);
  logic [W-1:0] cnt_q, lim;
  logic         en;

  always_comb begin
    en = 1'b1;
    unique case (wd_sel_e'(sel_i))
      SEL_LONG:  lim = W'(LONG_TICKS);
      SEL_MID:   lim = W'(MID_TICKS);
      SEL_SHORT: lim = W'(SHORT_TICKS);
      default: begin lim = W'(MAXL); en = 1'b0; end
    endcase
  end

  // >= covers a select change to a shorter interval mid-count.
  assign expire_o = en && !hold_i && !kick_i && (cnt_q >= lim - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (hold_i || !en || kick_i || expire_o) cnt_q <= '0;
    else                                          cnt_q <= cnt_q + W'(1);
  end

  p_wd_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(MAXL));
  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_OFF && $past(sel_i) == SEL_OFF) |-> (cnt_q == '0));
  p_kick_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));
  p_idle_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !expire_o);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned POR_TICKS      = 16,
  parameter int unsigned WD_LONG_TICKS  = 1000,
  parameter int unsigned WD_MID_TICKS   = 400,
  parameter int unsigned WD_SHORT_TICKS = 100,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter bit          ACTIVE_LOW     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       cs_ni,
  input  logic [1:0] wd_sel_i,
  output logic       sys_rst_o,
  output logic       cmd_block_o
);
  logic pwr_ok, cs_s, cs_q, kick, wd_expire, rst_act;

  rst_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_good_i), .q_o(pwr_ok));

  rst_sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_s;

  assign kick = cs_q & ~cs_s;

  rst_sup_wdog #(
    .LONG_TICKS(WD_LONG_TICKS), .MID_TICKS(WD_MID_TICKS), .SHORT_TICKS(WD_SHORT_TICKS)
  ) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(wd_sel_i), .kick_i(kick),
    .hold_i(rst_act), .expire_o(wd_expire));

  rst_sup_hold #(.POR_TICKS(POR_TICKS)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok),
    .wd_expire_i(wd_expire), .active_o(rst_act));

  if (ACTIVE_LOW) begin : g_pol_low
    assign sys_rst_o = ~rst_act;
  end else begin : g_pol_high
    assign sys_rst_o = rst_act;
  end

  assign cmd_block_o = rst_act;

  p_timeout_starts_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> rst_act);
  p_block_on_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_act) |-> cmd_block_o);
  p_supply_low_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_ok && $past(!pwr_ok)) |-> cmd_block_o);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int LL = 60;
  localparam int LM = 40;
  localparam int LS = 24;
  localparam int N  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b1;
  logic cs_n = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic rst_lo, blk_lo, rst_hi, blk_hi;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.POR_TICKS(P), .WD_LONG_TICKS(LL), .WD_MID_TICKS(LM),
    .WD_SHORT_TICKS(LS), .SYNC_STAGES(N), .ACTIVE_LOW(1'b1)) u_rst_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .cs_ni(cs_n),
    .wd_sel_i(wd_sel), .sys_rst_o(rst_lo), .cmd_block_o(blk_lo));

  rst_supervisor #(.POR_TICKS(P), .WD_LONG_TICKS(LL), .WD_MID_TICKS(LM),
    .WD_SHORT_TICKS(LS), .SYNC_STAGES(N), .ACTIVE_LOW(1'b0)) u_rst_supervisor_hi (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .cs_ni(cs_n),
    .wd_sel_i(wd_sel), .sys_rst_o(rst_hi), .cmd_block_o(blk_hi));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Outputs agree with each other and with the polarity option.
  task automatic chk_pins(input bit active);
    chk("R8 active-low pin", rst_lo, !active);
    chk("R8 active-high pin", rst_hi, active);
    chk("R2 busy", blk_lo, active);
  endtask

  // Count edges until the reset reaches the wanted level; samples at negedge.
  task automatic edges_until(input bit want, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (((!rst_lo) != want) && n < limit);
  endtask

  task automatic t_power_on();
    int n;
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk_pins(1'b1);                 // reset state
    rst_n = 1'b1;
    edges_until(1'b0, 1000, n);
    chk("R1 power-on hold", n, N + P);
    chk_pins(1'b0);
  endtask

  task automatic t_low_supply();
    int n;
    pwr_good = 1'b0;
    edges_until(1'b1, 1000, n);
    chk("R3 assert delay", n, N + 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R3 held while low", !rst_lo, 1);
    end
    chk_pins(1'b1);
    pwr_good = 1'b1;
    edges_until(1'b0, 1000, n);
    chk("R3 recovery hold", n, N + P);
  endtask

  task automatic t_timeout(input logic [1:0] sel, input int lim);
    int n;
    wd_sel = sel;
    for (int k = 0; k < 2; k++) begin
      edges_until(1'b1, 1000, n);
      chk("R4 timeout interval", n, lim);
      chk_pins(1'b1);
      edges_until(1'b0, 1000, n);
      chk("R7 pulse width", n, P);
    end
  endtask

  task automatic t_disabled();
    int n;
    wd_sel = 2'b11;
    edges_until(1'b1, 3*LL, n);
    chk("R5 no timeout when off", !rst_lo, 0);
    chk("R5 ran full window", n, 3*LL);
  endtask

  task automatic t_kick();
    int n;
    wd_sel = 2'b10;
    for (int j = 0; j < 10; j++) begin
      repeat (8) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1;
      chk("R6 periodic kicks keep reset off", !rst_lo, 0);
    end
    repeat (5) @(negedge clk);
    cs_n = 1'b0;                    // falls once, then held low
    edges_until(1'b1, 1000, n);
    chk("R6 timeout after single kick", n, N + 1 + LS);
    cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;                    // edge during reset pulse
    edges_until(1'b0, 1000, n);
    chk("R9 pulse with kick inside", n, P - 1);
    cs_n = 1'b1;
    edges_until(1'b1, 1000, n);
    chk("R9 next timeout unaffected", n, LS);
    edges_until(1'b0, 1000, n);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_power_on();
    t_low_supply();
    t_timeout(2'b00, LL);
    t_timeout(2'b01, LM);
    t_timeout(2'b10, LS);
    t_disabled();
    t_kick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule